// File: doc/BRIEF.md
# SPI Shift Data Register Unit

This block is the data path of a serial peripheral port. A single 8-bit shift register holds both the character to be sent and the character being received. The CPU writes it, and a read always shows its live contents. Bits leave from the top of the register, and bits received enter at the bottom. The unit can act as bus master, where it makes the serial clock from a programmable divider and drives its own active-low select. It can also act as slave, where it follows a clock and select from outside, each passed through a two-flop synchronizer. Transfers use SPI mode 0: the clock idles low, the serial output changes on the falling edge, and the serial input is sampled on the rising edge.

A character may be 1 to 8 bits long. A short character to send sits in the upper bits of the written byte. A short character received ends up in the lower bits. Any write while a transfer is running is dropped and sets a sticky overrun flag, which stays set until the clear input is pulsed.

A controller built around a state machine sequences the unit. `ST_IDLE` waits. In master mode, a write moves the controller to `ST_M_LOW`. From there, a divider tick raises the clock and samples a bit, then goes to `ST_M_HIGH`, or to `ST_M_STOP` after the last bit. A tick in `ST_M_HIGH` lowers the clock, puts out the next bit and returns to `ST_M_LOW`. `ST_M_STOP` returns to `ST_IDLE` after one clock. In slave mode, a low synchronized select moves `ST_IDLE` to `ST_S_XFER`. There, each synchronized rising clock samples a bit, and each falling clock puts out the next bit. The last bit moves the controller to `ST_S_END`, and a select that rises early aborts the transfer back to `ST_IDLE`. `ST_S_END` moves to `ST_S_HOLD` after one clock. `ST_S_HOLD` waits for the select to rise and then returns to `ST_IDLE`.

Top module: `spi_shift_unit`

## Requirements
- R1: After reset, rd_data is 0, busy, ovr, sck_o and ser_out are 0, and ss_n_o is 1. rd_data always shows the current shift register contents, including a partly shifted character.
- R2: Bits are sent starting with bit 7 of the shift register, and each received bit enters at bit 0, with the older contents moving up one place.
- R3: In master mode, a write while not busy loads wr_data. From the next clock on, busy is 1 and ss_n_o is 0.
- R4: In master mode, the first rising edge of sck_o comes clk_div+1 clocks after the load. Each later rising edge comes 2*(clk_div+1) clocks after the one before. ser_out changes only on falling edges of sck_o, and ss_n_o stays low for the whole character.
- R5: In slave mode, a write while not busy only loads the register, and busy stays 0. After ss_n_i falls, the controller reaches the transfer state within 3 clocks. The first bit sent is bit 7 of the preloaded byte.
- R6: In either mode, a write while busy leaves the shift register unchanged and sets ovr on the next clock.
- R7: ovr stays at 1 until ovr_clr is pulsed, and it is 0 on the clock after a clear that has no dropped write in the same cycle.
- R8: char_len gives the number of bits in a character, with 0 meaning 8. After L bits, rd_data equals the preloaded byte shifted left by L, with the L received bits in the lowest L positions. The L bits sent are the top L bits of the preloaded byte.
- R9: busy falls one clock after the clock edge that samples the last bit. In master mode, sck_o returns low and ss_n_o returns high on that same clock.
- R10: In slave mode, if ss_n_i rises before the last bit, the transfer is aborted, busy returns to 0, and rd_data keeps the bits shifted so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU write strobe for the data register |
| wr_data | input | 8 | CPU write data; a short character is placed in the upper bits |
| rd_data | output | 8 | Live shift register contents |
| is_master | input | 1 | 1 = master mode, 0 = slave mode; changed only while not busy |
| char_len | input | 3 | Bits per character; 0 means 8 |
| clk_div | input | 8 | Master half-period length minus one, in system clocks |
| sck_o | output | 1 | Master serial clock out; idles low |
| ss_n_o | output | 1 | Master active-low select out |
| sck_i | input | 1 | Slave serial clock in (asynchronous) |
| ss_n_i | input | 1 | Slave active-low select in (asynchronous) |
| ser_in | input | 1 | Serial data in (MISO as master, MOSI as slave) |
| ser_out | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| busy | output | 1 | A transfer is in progress |
| ovr | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clears ovr |

## Verification
The bench goes after the justification boundaries: 1-bit, 4-bit, 7-bit and 8-bit characters, where a design that decodes a length of 0 as 0 bits would stop early, or one that shifts the wrong way would scramble the preloaded upper bits. It measures the distance between master clock edges with a divider of 0, which is where a design that divides by N instead of N+1 would show up. It also checks the clock on which busy falls, because a design that drops busy one clock late would let a write in the closing clock be counted as overrun. It writes in the middle of a transfer in both modes, which a design without a guard would take as a reload of the data. It aborts slave transfers after zero bits and after some bits, where a design without an abort path would stay busy forever.

// File: rtl/spi_su_pkg.sv
package spi_su_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_M_LOW,
        ST_M_HIGH,
        ST_M_STOP,
        ST_S_XFER,
        ST_S_END,
        ST_S_HOLD
    } su_state_t;

endpackage

// File: rtl/spi_su_sync.sv
module spi_su_sync #(
    parameter int              WIDTH = 2,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic sync_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= INIT[g];
                sync_q <= INIT[g];
            end else begin
                meta_q <= async_i[g];
                sync_q <= meta_q;
            end
        end

        assign level_o[g] = sync_q;
    end

endmodule

// File: rtl/spi_su_clkgen.sv
module spi_su_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_su_ctrl.sv
module spi_su_ctrl
    import spi_su_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] char_len,
    input  logic             tick,
    input  logic             ss_lvl,
    input  logic             sck_rise,
    input  logic             sck_fall,
    output logic             load,
    output logic             sample,
    output logic             drive,
    output logic             div_run,
    output logic             busy,
    output logic             sck_o,
    output logic             ss_n_o
);

    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(1 << LEN_W);

    su_state_t        state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [CNT_W-1:0] eff_len;
    logic             last_bit;
    logic             clr_cnt;

    assign eff_len  = (char_len == '0) ? FULL_LEN : {1'b0, char_len};
    assign last_bit = (bit_cnt_q + 1'b1) == eff_len;

    // State register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (clr_cnt) begin
                bit_cnt_q <= '0;
            end else if (sample) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    // Next state and data path strobes
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        sample  = 1'b0;
        drive   = 1'b0;
        clr_cnt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (is_master) begin
                    if (wr_en) begin
                        load    = 1'b1;
                        drive   = 1'b1;
                        clr_cnt = 1'b1;
                        state_d = ST_M_LOW;
                    end
                end else begin
                    load = wr_en;
                    if (!ss_lvl) begin
                        drive   = 1'b1;
                        clr_cnt = 1'b1;
                        state_d = ST_S_XFER;
                    end
                end
            end
            ST_M_LOW: begin
                if (tick) begin
                    sample  = 1'b1;
                    state_d = last_bit ? ST_M_STOP : ST_M_HIGH;
                end
            end
            ST_M_HIGH: begin
                if (tick) begin
                    drive   = 1'b1;
                    state_d = ST_M_LOW;
                end
            end
            ST_M_STOP: begin
                state_d = ST_IDLE;
            end
            ST_S_XFER: begin
                if (ss_lvl) begin
                    state_d = ST_IDLE;
                end else if (sck_rise) begin
                    sample = 1'b1;
                    if (last_bit) begin
                        state_d = ST_S_END;
                    end
                end else if (sck_fall) begin
                    drive = 1'b1;
                end
            end
            ST_S_END: begin
                state_d = ST_S_HOLD;
            end
            ST_S_HOLD: begin
                load = wr_en;
                if (ss_lvl) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Moore outputs decoded from the state register
    always_comb begin
        busy    = 1'b0;
        sck_o   = 1'b0;
        ss_n_o  = 1'b1;
        div_run = 1'b0;
        unique case (state_q)
            ST_M_LOW: begin
                busy    = 1'b1;
                ss_n_o  = 1'b0;
                div_run = 1'b1;
            end
            ST_M_HIGH: begin
                busy    = 1'b1;
                ss_n_o  = 1'b0;
                sck_o   = 1'b1;
                div_run = 1'b1;
            end
            ST_M_STOP: begin
                busy   = 1'b1;
                ss_n_o = 1'b0;
                sck_o  = 1'b1;
            end
            ST_S_XFER, ST_S_END: begin
                busy = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int LEN_W = 3,
    parameter int DIV_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [(1<<LEN_W)-1:0]   wr_data,
    output logic [(1<<LEN_W)-1:0]   rd_data,
    input  logic                    is_master,
    input  logic [LEN_W-1:0]        char_len,
    input  logic [DIV_W-1:0]        clk_div,
    output logic                    sck_o,
    output logic                    ss_n_o,
    input  logic                    sck_i,
    input  logic                    ss_n_i,
    input  logic                    ser_in,
    output logic                    ser_out,
    output logic                    busy,
    output logic                    ovr,
    input  logic                    ovr_clr
);

    localparam int DATA_W = 1 << LEN_W;
    localparam int MSB    = DATA_W - 1;

    logic [DATA_W-1:0] shreg_q;
    logic              out_bit_q;
    logic              ovr_q;
    logic              sck_d_q;
    logic [1:0]        sync_lvl;
    logic              sck_lvl;
    logic              ss_lvl;
    logic              sck_rise;
    logic              sck_fall;
    logic              tick;
    logic              load;
    logic              sample;
    logic              drive;
    logic              div_run;

    spi_su_sync #(
        .WIDTH (2),
        .INIT  (2'b10)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ss_n_i, sck_i}),
        .level_o (sync_lvl)
    );

    assign sck_lvl  = sync_lvl[0];
    assign ss_lvl   = sync_lvl[1];
    assign sck_rise = sck_lvl & ~sck_d_q;
    assign sck_fall = ~sck_lvl & sck_d_q;

    spi_su_clkgen #(
        .DIV_W (DIV_W)
    ) i_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (div_run),
        .div   (clk_div),
        .tick  (tick)
    );

    spi_su_ctrl #(
        .LEN_W (LEN_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .wr_en     (wr_en),
        .char_len  (char_len),
        .tick      (tick),
        .ss_lvl    (ss_lvl),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .load      (load),
        .sample    (sample),
        .drive     (drive),
        .div_run   (div_run),
        .busy      (busy),
        .sck_o     (sck_o),
        .ss_n_o    (ss_n_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            out_bit_q <= 1'b0;
            ovr_q     <= 1'b0;
            sck_d_q   <= 1'b0;
        end else begin
            sck_d_q <= sck_lvl;
            if (load) begin
                shreg_q <= wr_data;
            end else if (sample) begin
                shreg_q <= {shreg_q[MSB-1:0], ser_in};
            end
            if (drive) begin
                out_bit_q <= load ? wr_data[MSB] : shreg_q[MSB];
            end
            if (wr_en && busy) begin
                ovr_q <= 1'b1;
            end else if (ovr_clr) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign rd_data = shreg_q;
    assign ser_out = out_bit_q;
    assign ovr     = ovr_q;

endmodule

// File: rtl/spi_su_checker.sv
module spi_su_checker #(
    parameter int LEN_W = 3,
    parameter int DIV_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [(1<<LEN_W)-1:0] wr_data,
    input logic [(1<<LEN_W)-1:0] rd_data,
    input logic                  is_master,
    input logic                  sck_o,
    input logic                  ss_n_o,
    input logic                  ser_out,
    input logic                  busy,
    input logic                  ovr,
    input logic                  ovr_clr
);

    AST_MASTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        is_master && !busy && wr_en |=> busy && !ss_n_o); // R3

    AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && wr_en |=> rd_data == $past(wr_data)); // R5

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_en |=> ovr); // R6

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && !ovr_clr |=> ovr); // R7

    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clr && !(busy && wr_en) |=> !ovr); // R7

    AST_SCK_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !ss_n_o); // R4

    AST_SELECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_n_o |-> busy); // R4

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        is_master && busy && $past(busy) && !$fell(sck_o) |-> $stable(ser_out)); // R4

    AST_MASTER_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        is_master && $fell(busy) |-> $past(sck_o) && !sck_o && ss_n_o); // R9

endmodule

bind spi_shift_unit spi_su_checker #(
    .LEN_W (LEN_W),
    .DIV_W (DIV_W)
) i_su_checker (.*);

// File: tb/test_spi_shift_unit.sv
module test_spi_shift_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       is_master = 1'b1;
    logic [2:0] char_len = 3'd0;
    logic [7:0] clk_div = 8'd0;
    logic       sck_o;
    logic       ss_n_o;
    logic       sck_i = 1'b0;
    logic       ss_n_i = 1'b1;
    logic       ser_in = 1'b0;
    logic       ser_out;
    logic       busy;
    logic       ovr;
    logic       ovr_clr = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    localparam int HALF = 4;

    always #5 clk = ~clk;

    spi_shift_unit i_spi_shift_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .is_master (is_master),
        .char_len  (char_len),
        .clk_div   (clk_div),
        .sck_o     (sck_o),
        .ss_n_o    (ss_n_o),
        .sck_i     (sck_i),
        .ss_n_i    (ss_n_i),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .busy      (busy),
        .ovr       (ovr),
        .ovr_clr   (ovr_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    function automatic int eff_len(input logic [2:0] cl);
        return (cl == 3'd0) ? 8 : int'(cl);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] pre, input logic [7:0] inb, input int k);
        logic [15:0] w;
        w = {8'h00, pre} << k;
        w = w | ({8'h00, inb} >> (8 - k));
        return w[7:0];
    endfunction

    function automatic int top_bits(input logic [7:0] v, input int k);
        return int'({8'h00, v} >> (8 - k));
    endfunction

    task automatic cpu_write(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic m_xfer(input logic [7:0] d, input logic [2:0] cl, input logic [7:0] dv,
                          input logic [7:0] sb, input bit inject);
        int   len;
        int   t;
        int   first_rise;
        int   prev_rise;
        int   last_rise;
        int   busy_end;
        int   rises;
        int   bi;
        bit   per_ok;
        bit   ss_ok;
        logic prev_sck;
        logic [7:0] txc;
        len = eff_len(cl);
        t = 0; first_rise = -1; prev_rise = -1; last_rise = -1; busy_end = -1;
        rises = 0; bi = 0; per_ok = 1'b1; ss_ok = 1'b1; txc = 8'h00;
        char_len = cl;
        clk_div  = dv;
        cpu_write(d);
        // R3: busy, select low and data loaded one clock after the write
        chk(busy === 1'b1 && ss_n_o === 1'b0 && rd_data === d, "R3 start", {busy, ss_n_o, rd_data}, {2'b10, d});
        ser_in   = sb[7];
        prev_sck = sck_o;
        if (inject) begin
            wr_en   = 1'b1;
            wr_data = ~d;
        end
        while (busy_end < 0 && t < 5000) begin
            @(negedge clk);
            t++;
            if (inject && t == 1) wr_en = 1'b0;
            if (busy && ss_n_o) ss_ok = 1'b0;
            if (sck_o && !prev_sck) begin
                txc = {txc[6:0], ser_out};
                if (first_rise < 0) first_rise = t;
                else if (t - prev_rise != 2 * (int'(dv) + 1)) per_ok = 1'b0;
                prev_rise = t;
                last_rise = t;
                rises++;
            end
            if (!sck_o && prev_sck && busy) begin
                bi++;
                ser_in = sb[7-bi];
            end
            if (!busy) busy_end = t;
            prev_sck = sck_o;
        end
        chk(first_rise == int'(dv) + 1, "R4 first edge", first_rise, int'(dv) + 1);
        chk(per_ok && ss_ok, "R4 period/select", {per_ok, ss_ok}, 2'b11);
        chk(sck_o === 1'b0 && ss_n_o === 1'b1, "R4 idle levels", {sck_o, ss_n_o}, 2'b01);
        chk(busy_end == last_rise + 1, "R9 busy end", busy_end, last_rise + 1);
        chk(rises == len, "R8 bit count", rises, len);
        chk(int'(txc) % (1 << len) == top_bits(d, len), "R2 tx order", int'(txc) % (1 << len), top_bits(d, len));
        chk(rd_data === exp_rd(d, sb, len), "R8 rx justify", rd_data, exp_rd(d, sb, len));
        if (inject) begin
            chk(ovr === 1'b1, "R6 overrun", ovr, 1);
        end
    endtask

    task automatic s_xfer(input logic [7:0] pre, input logic [2:0] cl, input logic [7:0] mb,
                          input int abort_k, input bit inject);
        int   len;
        int   k;
        logic [7:0] txc;
        len = eff_len(cl);
        k = 0;
        txc = 8'h00;
        char_len = cl;
        cpu_write(pre);
        repeat (10) @(negedge clk);
        // R5: a slave write only preloads
        chk(busy === 1'b0 && ss_n_o === 1'b1 && rd_data === pre, "R5 preload", {busy, ss_n_o, rd_data}, {2'b01, pre});
        ss_n_i = 1'b0;
        ser_in = mb[7];
        repeat (HALF) @(negedge clk);
        chk(busy === 1'b1, "R5 select starts", busy, 1);
        for (int i = 0; i < len; i++) begin
            if (i == abort_k) break;
            txc   = {txc[6:0], ser_out};
            sck_i = 1'b1;
            repeat (HALF) @(negedge clk);
            if (inject && i == 0) begin
                wr_en   = 1'b1;
                wr_data = ~pre;
                @(negedge clk);
                wr_en   = 1'b0;
            end
            sck_i  = 1'b0;
            ser_in = (i < 7) ? mb[6-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            k++;
        end
        if (abort_k >= 0) begin
            ss_n_i = 1'b1;
            repeat (6) @(negedge clk);
            chk(busy === 1'b0, "R10 abort busy", busy, 0);
            chk(rd_data === exp_rd(pre, mb, k), "R10 abort data", rd_data, exp_rd(pre, mb, k));
        end else begin
            chk(busy === 1'b0, "R9 slave busy end", busy, 0);
            chk(rd_data === exp_rd(pre, mb, len), "R8 slave rx", rd_data, exp_rd(pre, mb, len));
            chk(int'(txc) % (1 << len) == top_bits(pre, len), "R2 slave tx", int'(txc) % (1 << len), top_bits(pre, len));
            ss_n_i = 1'b1;
            repeat (6) @(negedge clk);
        end
        if (inject) begin
            chk(ovr === 1'b1, "R6 slave overrun", ovr, 1);
        end
    endtask

    task automatic clear_ovr();
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk(ovr === 1'b0, "R7 clear", ovr, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(rd_data === 8'h00 && busy === 1'b0 && ovr === 1'b0, "R1 reset", {rd_data, busy, ovr}, 0);
        chk(sck_o === 1'b0 && ss_n_o === 1'b1 && ser_out === 1'b0, "R1 reset pins", {sck_o, ss_n_o, ser_out}, 3'b010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Master directed corners
        is_master = 1'b1;
        m_xfer(8'hA5, 3'd0, 8'd0, 8'h3C, 1'b0);
        m_xfer(8'h9F, 3'd4, 8'd2, 8'hB0, 1'b0);
        m_xfer(8'h80, 3'd1, 8'd1, 8'h00, 1'b0);
        m_xfer(8'h5A, 3'd7, 8'd0, 8'hFF, 1'b0);
        m_xfer(8'hC3, 3'd0, 8'd3, 8'h69, 1'b1);
        repeat (5) @(negedge clk);
        chk(ovr === 1'b1, "R7 sticky", ovr, 1);
        clear_ovr();
        m_xfer(8'h01, 3'd1, 8'd0, 8'h80, 1'b1);
        clear_ovr();

        // Master random
        for (int n = 0; n < 14; n++) begin
            m_xfer(8'($urandom), 3'($urandom), 8'($urandom % 4), 8'($urandom), 1'b0);
        end
        chk(ovr === 1'b0, "R6 no false overrun", ovr, 0);

        // Slave directed corners
        is_master = 1'b0;
        s_xfer(8'hB4, 3'd0, 8'h2D, -1, 1'b0);
        s_xfer(8'hE0, 3'd4, 8'h70, -1, 1'b0);
        s_xfer(8'h80, 3'd1, 8'h80, -1, 1'b0);
        s_xfer(8'hCA, 3'd0, 8'hF1, 3, 1'b0);
        s_xfer(8'h3E, 3'd5, 8'h55, 0, 1'b0);
        s_xfer(8'h96, 3'd0, 8'h4B, -1, 1'b1);
        clear_ovr();

        // Slave random
        for (int n = 0; n < 6; n++) begin
            s_xfer(8'($urandom), 3'($urandom), 8'($urandom), -1, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule